// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic heart of a fixed-point signal-processing core. It holds four 24-bit operand registers (two on the X side, two on the Y side), a signed 24 by 24 multiplier that keeps the whole 48-bit product, and two 56-bit accumulators. Each accumulator has eight guard bits above the product, so long sums can run past the product's range without wrapping. A controller drives it with one opcode per cycle through a valid-qualified port, together with an accumulator select, a register select, a scale select and a 24-bit data word.

The multiplier is pipelined over two stages. Every accumulator operation retires two cycles after issue, strictly in issue order, so back-to-back accumulations into one accumulator build on each other without stalls. An accumulator can be shifted in place by one bit either way. It is read out through a scaler and limiter that rounds the value to 24 bits and clips it when it does not fit. Any clip sets a sticky flag.

Top module: `dsp_mac_unit`

## Requirements
- R1: Opcode 1 (load) writes op_data into the operand register picked by reg_sel (0 = X0, 1 = X1, 2 = Y0, 3 = Y1) at the end of its cycle. An operation issued in the next cycle already uses the new value.
- R2: Opcodes 3 (multiply), 4 (multiply-accumulate) and 5 (multiply-subtract) form the full signed 48-bit product of X (X1 if reg_sel[1] is 1, else X0) and Y (Y1 if reg_sel[0] is 1, else Y0). The product is sign-extended to 56 bits and then replaces the accumulator, is added to it or is subtracted from it, modulo 2^56. acc_sel picks A (0) or B (1).
- R3: An accumulator operation (opcodes 2 to 7) issued in cycle n acts on the accumulator at the end of cycle n+2. Such operations take effect in issue order, one per cycle, and each one sees the results of all the operations issued before it.
- R4: Sums that go beyond the 48-bit product range are kept exactly, up to the 56-bit range.
- R5: Opcode 2 (clear) sets the selected accumulator to zero in issue order. It overrides every accumulation into that accumulator issued before it, and later ones build on zero.
- R6: Opcode 6 (shift) moves the selected accumulator by one bit in place: scale_sel 1 shifts left, 2 shifts right arithmetically, 0 and 3 leave it unchanged. A left shift that overflows 56 bits clips to the largest or smallest 56-bit value.
- R7: Opcode 7 (read) scales the accumulator by 2 (scale_sel 1), by 1/2 (scale_sel 2) or by 1 (0 or 3). It keeps bits 47..24 of the scaled value, rounding half toward plus infinity. rd_data and a one-cycle rd_valid pulse appear in cycle n+3 for a read issued in cycle n.
- R8: If the rounded read value lies outside the signed 24-bit range, rd_data becomes 0x7FFFFF (positive) or 0x800000 (negative). sat_flag rises in the same cycle and stays high until reset.
- R9: rd_data holds its value between reads. Opcode 0 and cycles with op_valid low change no state.
- R10: While rst_n is low, the operand registers and accumulators are cleared, and rd_data, rd_valid and sat_flag are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Qualifies the opcode in this cycle |
| op_code | input | 3 | Operation: 0 nop, 1 load, 2 clear, 3 mpy, 4 mac, 5 msub, 6 shift, 7 read |
| acc_sel | input | 1 | Accumulator: 0 = A, 1 = B |
| reg_sel | input | 2 | Operand register for load; X/Y choice for multiplies |
| scale_sel | input | 2 | Shift direction or read scale |
| op_data | input | 24 | Operand value for load |
| rd_data | output | 24 | Scaled, rounded, limited read result |
| rd_valid | output | 1 | One-cycle pulse with each read result |
| sat_flag | output | 1 | Sticky limiter clip indicator |

## Verification
The bench goes after back-to-back accumulations into one accumulator. A design without correct ordering in its pipeline would lose or repeat a product there. It checks a clear issued right behind a multiply-accumulate, where an out-of-order write would leave a stale product behind. It drives sums past 2^48 and then shifts them right, which exposes any design that dropped its guard bits. Reads at exactly half an LSB of either sign catch a wrong rounding direction. Left shifts and reads that overflow catch a wrap where a clip is required, and a flag that is not sticky.

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit #(
  parameter int DW    = 24,
  parameter int GUARD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic          acc_sel,
  input  logic [1:0]    reg_sel,
  input  logic [1:0]    scale_sel,
  input  logic [DW-1:0] op_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          sat_flag
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GUARD;
  localparam int TW = AW + 3;
  localparam logic [2:0] OP_LOAD = 3'd1, OP_CLR = 3'd2, OP_MPY = 3'd3, OP_MAC = 3'd4,
                         OP_MSU = 3'd5, OP_SHF = 3'd6, OP_RD = 3'd7;
  localparam logic [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};
  localparam logic [TW-1:0] HALF_LSB = TW'(1) << DW;

  logic [DW-1:0] opr [4];
  logic [AW-1:0] acc [2];

  logic          s1_v, s2_v;
  logic [2:0]    s1_op, s2_op;
  logic          s1_a, s2_a;
  logic [1:0]    s1_sc, s2_sc;
  logic signed [DW-1:0] s1_x, s1_y;
  logic signed [PW-1:0] s2_p;

  wire issue_acc = op_valid && (op_code >= OP_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) opr[i] <= '0;
    end else if (op_valid && op_code == OP_LOAD) begin
      opr[reg_sel] <= op_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0;
      s1_op <= '0; s2_op <= '0; s1_a <= 1'b0; s2_a <= 1'b0;
      s1_sc <= '0; s2_sc <= '0; s1_x <= '0; s1_y <= '0; s2_p <= '0;
    end else begin
      s1_v  <= issue_acc;
      s1_op <= op_code;
      s1_a  <= acc_sel;
      s1_sc <= scale_sel;
      s1_x  <= opr[{1'b0, reg_sel[1]}];
      s1_y  <= opr[{1'b1, reg_sel[0]}];
      s2_v  <= s1_v;
      s2_op <= s1_op;
      s2_a  <= s1_a;
      s2_sc <= s1_sc;
      s2_p  <= s1_x * s1_y;
    end
  end

  wire [AW-1:0] cur  = acc[s2_a];
  wire [AW-1:0] prod = {{GUARD{s2_p[PW-1]}}, s2_p};
  wire          lovf = cur[AW-1] ^ cur[AW-2];
  wire [AW-1:0] shl  = lovf ? (cur[AW-1] ? ACC_MIN : ACC_MAX) : {cur[AW-2:0], 1'b0};
  wire [AW-1:0] shr  = {cur[AW-1], cur[AW-1:1]};

  logic [AW-1:0] nxt;
  always_comb begin
    case (s2_op)
      OP_CLR:  nxt = '0;
      OP_MPY:  nxt = prod;
      OP_MAC:  nxt = cur + prod;
      OP_MSU:  nxt = cur - prod;
      OP_SHF:  nxt = (s2_sc == 2'd1) ? shl : (s2_sc == 2'd2) ? shr : cur;
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc[0] <= '0;
      acc[1] <= '0;
    end else if (s2_v && s2_op != OP_RD) begin
      acc[s2_a] <= nxt;
    end
  end

  logic signed [TW-1:0] scaled, rounded;
  always_comb begin
    scaled = TW'($signed(cur));
    if (s2_sc == 2'd1)      scaled = scaled <<< 2;
    else if (s2_sc != 2'd2) scaled = scaled <<< 1;
    rounded = (scaled + $signed(HALF_LSB)) >>> (DW + 1);
  end

  wire [TW-DW:0] upper = rounded[TW-1:DW-1];
  wire           fits  = (&upper) | ~(|upper);
  wire [DW-1:0]  clip  = rounded[TW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  wire           rd_go = s2_v && s2_op == OP_RD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        rd_data <= fits ? rounded[DW-1:0] : clip;
        if (!fits) sat_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsp_mac_unit_chk.sv
module dsp_mac_unit_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          sat_flag
);
  wire rd_issue = op_valid && op_code == 3'd7;

  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> ##3 rd_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_issue, 3));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);

  a_r8_clip_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> rd_valid &&
      (rd_data == {1'b0, {(DW-1){1'b1}}} || rd_data == {1'b1, {(DW-1){1'b0}}}));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

bind dsp_mac_unit dsp_mac_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .rd_data(rd_data), .rd_valid(rd_valid), .sat_flag(sat_flag)
);

// File: tb/test_dsp_mac_unit.sv
module test_dsp_mac_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        acc_sel = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [1:0]  scale_sel = '0;
  logic [23:0] op_data = '0;
  logic [23:0] rd_data;
  logic        rd_valid;
  logic        sat_flag;

  dsp_mac_unit i_dsp_mac_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .reg_sel(reg_sel), .scale_sel(scale_sel),
    .op_data(op_data), .rd_data(rd_data), .rd_valid(rd_valid), .sat_flag(sat_flag)
  );

  typedef struct { bit v; int op; int a; longint p; int sc; } pend_t;
  pend_t  p1, p2;
  longint m_acc [2];
  longint m_opr [4];
  logic [23:0] e_rd;
  bit     e_rv, e_sat;
  int     n_cmp = 0, n_bad = 0;
  string  req = "R10";
  bit     done = 1'b0;

  localparam longint A_MAX = (64'sd1 <<< 55) - 1;
  localparam longint A_MIN = -(64'sd1 <<< 55);

  function automatic longint sx24(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint wrap56(longint v);
    return (v <<< 8) >>> 8;
  endfunction

  task automatic exec(pend_t q);
    longint t, r;
    e_rv = 1'b0;
    if (!q.v) return;
    case (q.op)
      2: m_acc[q.a] = 0;
      3: m_acc[q.a] = q.p;
      4: m_acc[q.a] = wrap56(m_acc[q.a] + q.p);
      5: m_acc[q.a] = wrap56(m_acc[q.a] - q.p);
      6: begin
        if (q.sc == 1) begin
          t = m_acc[q.a] * 2;
          m_acc[q.a] = (t > A_MAX) ? A_MAX : (t < A_MIN) ? A_MIN : t;
        end else if (q.sc == 2) m_acc[q.a] = m_acc[q.a] >>> 1;
      end
      7: begin
        t = m_acc[q.a];
        if (q.sc == 1) t = t * 4;
        else if (q.sc != 2) t = t * 2;
        r = (t + (64'sd1 <<< 24)) >>> 25;
        e_rv = 1'b1;
        if (r > 64'sd8388607)       begin e_rd = 24'h7FFFFF; e_sat = 1'b1; end
        else if (r < -64'sd8388608) begin e_rd = 24'h800000; e_sat = 1'b1; end
        else e_rd = r[23:0];
      end
      default: ;
    endcase
  endtask

  task automatic compare();
    n_cmp++;
    if (rd_valid !== e_rv || rd_data !== e_rd || sat_flag !== e_sat) begin
      n_bad++;
      $display("FAIL %s: actual rv=%0b rd=%06h sat=%0b expected rv=%0b rd=%06h sat=%0b",
               req, rd_valid, rd_data, sat_flag, e_rv, e_rd, e_sat);
    end
  endtask

  task automatic issue(bit v, int op, int a, int rs, int sc, logic [23:0] d);
    pend_t c;
    op_valid = v; op_code = op[2:0]; acc_sel = a[0]; reg_sel = rs[1:0];
    scale_sel = sc[1:0]; op_data = d;
    c.v = v && op >= 2; c.op = op; c.a = a; c.sc = sc;
    c.p = m_opr[rs[1]] * m_opr[2 + rs[0]];
    @(posedge clk);
    exec(p2);
    p2 = p1;
    p1 = c;
    if (v && op == 1) m_opr[rs] = sx24(d);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(1'b0, 0, 0, 0, 0, 24'h0);
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    p1 = '{0, 0, 0, 0, 0}; p2 = p1;
    m_acc[0] = 0; m_acc[1] = 0;
    for (int i = 0; i < 4; i++) m_opr[i] = 0;
    e_rd = '0; e_rv = 1'b0; e_sat = 1'b0;
    repeat (3) @(negedge clk);
    req = "R10"; compare();
    rst_n = 1'b1;

    // R1 R2 R3: load, multiply, back-to-back accumulate into one accumulator
    req = "R1";
    issue(1, 1, 0, 0, 0, 24'h400000);
    issue(1, 1, 0, 2, 0, 24'h300000);
    issue(1, 3, 0, 0, 0, 0);
    req = "R3";
    issue(1, 1, 0, 1, 0, 24'hC00000);
    issue(1, 4, 0, 2, 0, 0);
    issue(1, 4, 0, 0, 0, 0);
    issue(1, 7, 0, 0, 0, 0);
    idle(3);
    // R2: multiply-subtract into B with negative operands
    req = "R2";
    issue(1, 1, 0, 3, 0, 24'hF12345);
    issue(1, 5, 1, 3, 0, 0);
    issue(1, 5, 1, 1, 0, 0);
    issue(1, 7, 1, 0, 0, 0);
    issue(1, 7, 0, 0, 3, 0);
    idle(3);
    // R4: sums past the product range kept by guard bits
    req = "R4";
    issue(1, 1, 0, 0, 0, 24'h800000);
    issue(1, 1, 0, 2, 0, 24'h800000);
    issue(1, 2, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) issue(1, 4, 0, 0, 0, 0);
    issue(1, 6, 0, 0, 2, 0);
    issue(1, 6, 0, 0, 2, 0);
    issue(1, 6, 0, 0, 2, 0);
    issue(1, 7, 0, 0, 0, 0);
    idle(3);
    // R5: clear right behind accumulates discards them; later ones build on zero
    req = "R5";
    issue(1, 4, 1, 0, 0, 0);
    issue(1, 2, 1, 0, 0, 0);
    issue(1, 7, 1, 0, 0, 0);
    issue(1, 2, 1, 0, 0, 0);
    issue(1, 5, 1, 0, 0, 0);
    issue(1, 7, 1, 0, 2, 0);
    idle(3);
    // R7: rounding at exactly half an LSB, both signs, and all scales
    req = "R7";
    issue(1, 1, 0, 0, 0, 24'h001000);
    issue(1, 1, 0, 2, 0, 24'h001000);
    issue(1, 3, 0, 0, 0, 0);
    issue(1, 7, 0, 0, 2, 0);
    issue(1, 7, 0, 0, 0, 0);
    issue(1, 7, 0, 0, 1, 0);
    issue(1, 1, 0, 3, 0, 24'hFFF000);
    issue(1, 3, 0, 1, 0, 0);
    issue(1, 7, 0, 0, 2, 0);
    issue(1, 7, 0, 0, 0, 0);
    idle(3);
    // R9: nops and idle cycles change nothing; R6 shift modes 0 and 3 hold
    req = "R9";
    issue(1, 0, 0, 0, 0, 24'h123456);
    issue(0, 1, 0, 0, 0, 24'h7FFFFF);
    issue(0, 2, 0, 0, 0, 0);
    issue(1, 6, 0, 0, 0, 0);
    issue(1, 6, 0, 0, 3, 0);
    issue(1, 3, 0, 0, 0, 0);
    issue(1, 7, 0, 0, 0, 0);
    idle(4);
    // R6 R8: left shifts that overflow clip; reads clip and raise the sticky flag
    req = "R6";
    issue(1, 1, 0, 0, 0, 24'h7FFFFF);
    issue(1, 1, 0, 2, 0, 24'h7FFFFF);
    issue(1, 3, 0, 0, 0, 0);
    issue(1, 3, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) issue(1, 6, 0, 0, 1, 0);
    issue(1, 5, 1, 0, 0, 0);
    issue(1, 5, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) issue(1, 6, 1, 0, 1, 0);
    req = "R8";
    issue(1, 7, 0, 0, 2, 0);
    issue(1, 7, 1, 0, 2, 0);
    idle(5);
    issue(1, 2, 0, 0, 0, 0);
    issue(1, 7, 0, 0, 0, 0);
    idle(3);

    // R3 random mix of all opcodes, compared every cycle
    req = "R3";
    for (int i = 0; i < 600; i++) begin
      int op, sc;
      logic [23:0] d;
      op = $urandom_range(0, 7);
      sc = $urandom_range(0, 3);
      d  = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? 24'h7FFFFF : 24'h800000)
                                       : 24'($urandom());
      issue($urandom_range(0, 4) != 0, op, $urandom_range(0, 1), $urandom_range(0, 3), sc, d);
    end
    idle(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule